// File: doc/BRIEF.md
# Bitplane Refresh Sweep Scheduler

This block decides the order in which a multiplexed LED panel's row shifter loads and latches bitplanes. The panel has 16 scanned rows. For each row the scheduler hands out one command at a time. A command is a row index and a plane index. Higher planes come round more often, so the time each plane is shown follows its binary weight. Each row opens with one pass over every plane from the lowest up. Partial passes then follow. Each partial pass starts at some plane above a split point and runs up to the top plane. The number of partial passes doubles each time the starting plane moves up by one. Planes at or below the split point are therefore visited only once per row.

The scheduler talks to the row shifter with a valid/done handshake. A command stays on the outputs until the shifter reports done. The next command then appears on the following cycle. The frame repeats with no gaps. A flag marks the final command of each frame. The plane count and the split point are set on configuration inputs. They are captured as a frame begins, so the image never changes its weighting partway down the panel. Dropping the enable lets the command in flight finish and then holds the scheduler idle. When the enable returns, the scheduler resumes at the point where it stopped.

Top module: `bitplane_sweep_sched`

## Requirements
- R1: After synchronous reset, cmd_valid and cmd_eof are low. The first command issued once en is high is row 0, plane 0.
- R2: Each row starts with a full pass: planes 0, 1, …, N−1 in ascending order, all for that row.
- R3: After the full pass, for each start plane i from t+1 up to N−1 (i increasing), the row gets 2^(i−t−1) passes, each covering planes i through N−1 in ascending order.
- R4: Rows are served in order 0 through 15. After the last command of row 15, the next command is row 0, plane 0.
- R5: cmd_eof is high together with the final command of each frame and low with every other command.
- R6: While cmd_valid is high and cmd_done is low, cmd_valid, cmd_row, cmd_plane and cmd_eof hold their values. A command is consumed only on a cycle with cmd_valid and cmd_done both high. The next command is presented on the next cycle.
- R7: N (cfg_planes) and t (cfg_trans) are captured when the first command of a frame is presented. Changing them later in the frame has no effect until the next frame.
- R8: If en is low on the cycle a command is consumed, cmd_valid goes low on the next cycle and stays low while en is low. With en low and cmd_valid low, no command is issued. When en returns, the next command in sequence is issued.
- R9: cfg_planes = 0 is treated as N = 1. A value above MAX_PLANES is treated as MAX_PLANES. A cfg_trans of N or more is treated as t = N−1.
- R10: With t = N−1, each row consists of the single full pass only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops after the command in flight |
| cfg_planes | input | $clog2(MAX_PLANES+1) | Plane count N |
| cfg_trans | input | $clog2(MAX_PLANES+1) | Split point t; planes at or below it are visited once per row |
| cmd_done | input | 1 | Row shifter has finished the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_row | output | $clog2(ROWS) | Row index of the command |
| cmd_plane | output | $clog2(MAX_PLANES+1) | Plane index of the command |
| cmd_eof | output | 1 | Current command is the last of the frame |

## Verification
The hardest states to reach from the ports are the frame boundary under a pending configuration change and a stop-and-resume taken in the middle of a row. The bench changes the configuration right after the first command of every frame has been checked. The new values must then be ignored until the wrap and obeyed from the next frame's first command. It drops the enable on chosen commands deep inside a row and checks that the exact next command in sequence is issued on resume. Full frames are compared against a sequence that the bench computes from nested loops over rows, start planes and repeat counts. These frames cover the widest plane count at the lowest split point, a one-pass-only split, and clamped inputs.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic {
    SWEEP_FULL = 1'b0,
    SWEEP_TAIL = 1'b1
  } sweep_kind_e;
endpackage

// File: rtl/bps_cfg_clamp.sv
module bps_cfg_clamp #(
  parameter int MAX_PLANES = 8,
  localparam int PLW = $clog2(MAX_PLANES + 1)
) (
  input  logic [PLW-1:0] raw_planes,
  input  logic [PLW-1:0] raw_trans,
  output logic [PLW-1:0] planes,
  output logic [PLW-1:0] trans
);
  localparam logic [PLW-1:0] MAXV = PLW'(MAX_PLANES);

  always_comb begin
    if (raw_planes == '0)
      planes = PLW'(1);
    else if (raw_planes > MAXV)
      planes = MAXV;
    else
      planes = raw_planes;
    if (raw_trans >= planes)
      trans = planes - 1'b1;
    else
      trans = raw_trans;
  end
endmodule

// File: rtl/bps_step.sv
module bps_step
  import bps_pkg::*;
#(
  parameter int MAX_PLANES = 8,
  parameter int ROWS = 16,
  localparam int PLW = $clog2(MAX_PLANES + 1),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int REPW = MAX_PLANES
) (
  input  logic [RW-1:0]   row,
  input  logic [PLW-1:0]  plane,
  input  logic [PLW-1:0]  lo,
  input  logic [REPW-1:0] rep,
  input  logic [PLW-1:0]  n,
  input  logic [PLW-1:0]  t,
  output logic [RW-1:0]   nrow,
  output logic [PLW-1:0]  nplane,
  output logic [PLW-1:0]  nlo,
  output logic [REPW-1:0] nrep,
  output logic            wrap
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  sweep_kind_e     kind;
  logic [PLW-1:0]  n_m1;
  logic [REPW-1:0] rep_lim;
  logic [PLW-1:0]  lo_c;
  logic [REPW-1:0] rep_c;

  assign kind    = (lo == '0) ? SWEEP_FULL : SWEEP_TAIL;
  assign n_m1    = n - 1'b1;
  assign rep_lim = REPW'(1) << (lo - t - 1'b1);

  always_comb begin
    nrow   = row;
    nplane = plane;
    nlo    = lo;
    nrep   = rep;
    wrap   = 1'b0;
    lo_c   = lo;
    rep_c  = rep;
    if (plane != n_m1) begin
      nplane = plane + 1'b1;
    end else begin
      if (kind == SWEEP_FULL) begin
        lo_c  = t + 1'b1;
        rep_c = '0;
      end else if ((rep + 1'b1) < rep_lim) begin
        rep_c = rep + 1'b1;
      end else begin
        lo_c  = lo + 1'b1;
        rep_c = '0;
      end
      if (lo_c >= n) begin
        nlo    = '0;
        nrep   = '0;
        nplane = '0;
        if (row == LAST_ROW) begin
          nrow = '0;
          wrap = 1'b1;
        end else begin
          nrow = row + 1'b1;
        end
      end else begin
        nlo    = lo_c;
        nrep   = rep_c;
        nplane = lo_c;
      end
    end
  end
endmodule

// File: rtl/bps_last_det.sv
module bps_last_det
  import bps_pkg::*;
#(
  parameter int MAX_PLANES = 8,
  parameter int ROWS = 16,
  localparam int PLW = $clog2(MAX_PLANES + 1),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int REPW = MAX_PLANES
) (
  input  logic [RW-1:0]   row,
  input  logic [PLW-1:0]  plane,
  input  logic [PLW-1:0]  lo,
  input  logic [REPW-1:0] rep,
  input  logic [PLW-1:0]  n,
  input  logic [PLW-1:0]  t,
  output logic            last
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  sweep_kind_e     kind;
  logic [PLW-1:0]  n_m1;
  logic [REPW-1:0] top_reps;
  logic            last_pass;

  assign kind     = (lo == '0) ? SWEEP_FULL : SWEEP_TAIL;
  assign n_m1     = n - 1'b1;
  assign top_reps = REPW'(1) << (n_m1 - t - 1'b1);

  always_comb begin
    if (kind == SWEEP_FULL)
      last_pass = (t == n_m1);
    else
      last_pass = (lo == n_m1) && (rep == top_reps - 1'b1);
  end

  assign last = (row == LAST_ROW) && (plane == n_m1) && last_pass;
endmodule

// File: rtl/bitplane_sweep_sched.sv
module bitplane_sweep_sched #(
  parameter int MAX_PLANES = 8,
  parameter int ROWS = 16,
  localparam int PLW = $clog2(MAX_PLANES + 1),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int REPW = MAX_PLANES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [PLW-1:0] cfg_planes,
  input  logic [PLW-1:0] cfg_trans,
  input  logic           cmd_done,
  output logic           cmd_valid,
  output logic [RW-1:0]  cmd_row,
  output logic [PLW-1:0] cmd_plane,
  output logic           cmd_eof
);
  logic [RW-1:0]   row_q, row_s, row_n;
  logic [PLW-1:0]  plane_q, plane_s, plane_n;
  logic [PLW-1:0]  lo_q, lo_s, lo_n;
  logic [REPW-1:0] rep_q, rep_s, rep_n;
  logic [PLW-1:0]  n_q, t_q, n_in, t_in, n_n, t_n;
  logic            valid_q, valid_n, eof_q, last_n;
  logic            wrap_s, advance, at_start, load_cfg;

  bps_cfg_clamp #(.MAX_PLANES(MAX_PLANES)) clamp_i (
    .raw_planes(cfg_planes), .raw_trans(cfg_trans),
    .planes(n_in), .trans(t_in)
  );

  bps_step #(.MAX_PLANES(MAX_PLANES), .ROWS(ROWS)) step_i (
    .row(row_q), .plane(plane_q), .lo(lo_q), .rep(rep_q),
    .n(n_q), .t(t_q),
    .nrow(row_s), .nplane(plane_s), .nlo(lo_s), .nrep(rep_s),
    .wrap(wrap_s)
  );

  assign advance  = valid_q & cmd_done;
  assign at_start = (row_q == '0) && (plane_q == '0) && (lo_q == '0) && (rep_q == '0);
  assign load_cfg = (advance & wrap_s) | (~valid_q & at_start);

  always_comb begin
    if (advance) begin
      row_n   = row_s;
      plane_n = plane_s;
      lo_n    = lo_s;
      rep_n   = rep_s;
      valid_n = en;
    end else begin
      row_n   = row_q;
      plane_n = plane_q;
      lo_n    = lo_q;
      rep_n   = rep_q;
      valid_n = valid_q | en;
    end
    n_n = load_cfg ? n_in : n_q;
    t_n = load_cfg ? t_in : t_q;
  end

  bps_last_det #(.MAX_PLANES(MAX_PLANES), .ROWS(ROWS)) last_i (
    .row(row_n), .plane(plane_n), .lo(lo_n), .rep(rep_n),
    .n(n_n), .t(t_n), .last(last_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      plane_q <= '0;
      lo_q    <= '0;
      rep_q   <= '0;
      n_q     <= PLW'(1);
      t_q     <= '0;
      valid_q <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      row_q   <= row_n;
      plane_q <= plane_n;
      lo_q    <= lo_n;
      rep_q   <= rep_n;
      n_q     <= n_n;
      t_q     <= t_n;
      valid_q <= valid_n;
      eof_q   <= valid_n & last_n;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_row   = row_q;
  assign cmd_plane = plane_q;
  assign cmd_eof   = eof_q;
endmodule

// File: rtl/bps_sched_chk.sv
module bps_sched_chk #(
  parameter int MAX_PLANES = 8,
  parameter int ROWS = 16,
  localparam int PLW = $clog2(MAX_PLANES + 1),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           cmd_done,
  input logic           cmd_valid,
  input logic [RW-1:0]  cmd_row,
  input logic [PLW-1:0] cmd_plane,
  input logic           cmd_eof
);
  localparam logic [RW-1:0]  LAST_ROW = RW'(ROWS - 1);
  localparam logic [PLW-1:0] MAXV     = PLW'(MAX_PLANES);

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_row) && $stable(cmd_plane) && $stable(cmd_eof)); // R6
  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_done && !en |=> !cmd_valid); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid && !en |=> !cmd_valid); // R8
  AST_NEXT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_done && en |=> cmd_valid); // R6
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_done && cmd_eof && en |=> cmd_row == '0 && cmd_plane == '0); // R4
  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_done && !cmd_eof && en |=>
      (cmd_row == $past(cmd_row) || cmd_row == $past(cmd_row) + 1'b1)); // R4
  AST_EOF_LAST_ROW: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_eof |-> cmd_row == LAST_ROW); // R5
  AST_PLANE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_plane < MAXV); // R9
endmodule

bind bitplane_sweep_sched bps_sched_chk #(.MAX_PLANES(MAX_PLANES), .ROWS(ROWS)) chk_i (
  .clk(clk), .rst(rst), .en(en), .cmd_done(cmd_done), .cmd_valid(cmd_valid),
  .cmd_row(cmd_row), .cmd_plane(cmd_plane), .cmd_eof(cmd_eof)
);

// File: tb/bitplane_sweep_sched_tb.sv
module bitplane_sweep_sched_tb_top;
  localparam int MAXP = 8;
  localparam int NROWS = 16;
  localparam int PLW = $clog2(MAXP + 1);
  localparam int RW = $clog2(NROWS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [PLW-1:0] cfg_planes = '0;
  logic [PLW-1:0] cfg_trans = '0;
  logic cmd_done = 1'b0;
  logic cmd_valid, cmd_eof;
  logic [RW-1:0] cmd_row;
  logic [PLW-1:0] cmd_plane;

  int nchk = 0;
  int nfail = 0;
  int cur_idx, cur_total, cur_dis, nxt_n, nxt_t;
  string cur_tag;

  always #5 clk = ~clk;

  bitplane_sweep_sched #(.MAX_PLANES(MAXP), .ROWS(NROWS)) dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_planes(cfg_planes), .cfg_trans(cfg_trans),
    .cmd_done(cmd_done), .cmd_valid(cmd_valid), .cmd_row(cmd_row),
    .cmd_plane(cmd_plane), .cmd_eof(cmd_eof)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", tag, cur_tag, what, act, exp);
    end
  endtask

  task automatic one_cmd(input int r, input int p, input bit full);
    int extra;
    int h_row, h_plane;
    while (!cmd_valid) @(negedge clk);
    chk(int'(cmd_row) == r, "R4", "row", int'(cmd_row), r);
    chk(int'(cmd_plane) == p, full ? "R2" : "R3", "plane", int'(cmd_plane), p);
    chk(cmd_eof == (cur_idx == cur_total - 1), "R5", "eof", int'(cmd_eof), int'(cur_idx == cur_total - 1));
    if (cur_idx == 0) begin
      cfg_planes = PLW'(nxt_n);
      cfg_trans  = PLW'(nxt_t);
    end
    h_row = int'(cmd_row);
    h_plane = int'(cmd_plane);
    extra = cur_idx % 3;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      chk(cmd_valid && int'(cmd_row) == h_row && int'(cmd_plane) == h_plane,
          "R6", "held command", int'(cmd_plane), h_plane);
    end
    if (cur_idx == cur_dis) en = 1'b0;
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    if (cur_idx == cur_dis) begin
      chk(!cmd_valid, "R8", "valid after disable", int'(cmd_valid), 0);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!cmd_valid, "R8", "valid while disabled", int'(cmd_valid), 0);
      end
      en = 1'b1;
    end
    cur_idx++;
  endtask

  task automatic do_frame(input int n, input int t, input int nn, input int nt, input int dis, input string tag);
    int per_row;
    per_row = n;
    for (int i = t + 1; i < n; i++) per_row += (1 << (i - t - 1)) * (n - i);
    cur_total = NROWS * per_row;
    cur_idx = 0;
    cur_dis = dis;
    nxt_n = nn;
    nxt_t = nt;
    cur_tag = tag;
    for (int r = 0; r < NROWS; r++) begin
      for (int p = 0; p < n; p++) one_cmd(r, p, 1'b1);
      for (int i = t + 1; i < n; i++)
        for (int k = 0; k < (1 << (i - t - 1)); k++)
          for (int p = i; p < n; p++) one_cmd(r, p, 1'b0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    cur_tag = "reset";
    cfg_planes = PLW'(4);
    cfg_trans = PLW'(1);
    repeat (3) @(negedge clk);
    chk(!cmd_valid, "R1", "valid in reset", int'(cmd_valid), 0);
    chk(!cmd_eof, "R1", "eof in reset", int'(cmd_eof), 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_valid, "R8", "idle with en low", int'(cmd_valid), 0);
    end
    en = 1'b1;
    do_frame(4, 1, 8, 0, 5, "R1 first frame");
    do_frame(8, 0, 1, 0, -1, "R7 config captured at wrap");
    do_frame(1, 0, 0, 0, -1, "R3 single plane");
    do_frame(1, 0, 3, 7, -1, "R9 zero planes clamped");
    do_frame(3, 2, 4, 3, 7, "R9 split clamped");
    do_frame(4, 3, 5, 2, -1, "R10 one pass per row");
    do_frame(5, 2, 5, 2, 40, "R7 frame after change");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule